// File: doc/BRIEF.md
# UART Receive Character Queue with Per-Entry Status

This block sits between a UART's serial deserializer and the host bus. Each time the deserializer reports a finished character, the block stores the byte together with three error flags: parity error, framing error and break. Short characters are padded with zero bits at the top before they are stored. The host sees the oldest stored character on a combinational data port and the error flags of that same character on a status port. A data read strobe removes that character from the queue. A status read strobe leaves the queue untouched, so a status read followed by a data read always returns a matched flag and byte pair.

An access-select input models the register bank switch of the bus. While it is high, the data port reads zero and data read strobes are ignored. A sticky overrun flag records that a character arrived with no free slot and was thrown away. A queue-clear input empties the queue and drops all stored flags in a single cycle.

Top module: `rx_char_queue`

## Requirements
- R1: After a synchronous active-low reset, `stat_rdy`, `stat_perr`, `stat_ferr`, `stat_brk` and `stat_ovr` are 0 and `rd_data` is 0x00.
- R2: While `sel_alt` is 0 and the queue is not empty, `rd_data` shows the oldest stored character. Each accepted data read removes it, so characters leave in arrival order, and the next one shows in the cycle after the read edge.
- R3: `char_len` selects the character width: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Bits of `char_data` at and above that width are stored as 0. Bit 0 is the first serial bit and is kept in place.
- R4: When the queue is not empty, `stat_perr`, `stat_ferr` and `stat_brk` show the flags that arrived with the head character. When the queue is empty they read 0.
- R5: A `stat_rd` strobe removes nothing. The head character and its flags are unchanged after it.
- R6: While `sel_alt` is 1, `rd_data` reads 0x00 and `data_rd` removes nothing.
- R7: The queue holds DEPTH characters (16 by default). A character that arrives while the queue is full, with no accepted read in the same cycle, is discarded. `stat_ovr` is then 1 from the next cycle until a `stat_rd` cycle that has no new discard.
- R8: A character that arrives while the queue is full, in the same cycle as an accepted data read, is stored and does not set `stat_ovr`.
- R9: `stat_rdy` is 1 exactly when the queue holds at least one character.
- R10: A data read on an empty queue returns 0x00 and leaves the queue empty. A later character is then the next one read.
- R11: `fifo_clr` empties the queue and clears `stat_ovr` at the next edge. It overrides a character or a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_clr | input | 1 | Empties the queue and clears the stored flags |
| char_vld | input | 1 | One-cycle strobe from the deserializer: a character is complete |
| char_data | input | 8 | Received bits, bit 0 first on the line |
| char_len | input | 2 | Character width code (0 to 3 for 5 to 8 bits) |
| char_perr | input | 1 | Parity error for this character |
| char_ferr | input | 1 | Framing error for this character |
| char_brk | input | 1 | Break condition for this character |
| sel_alt | input | 1 | Access select; 1 blocks data reads |
| data_rd | input | 1 | Data register read strobe (removes the head) |
| stat_rd | input | 1 | Status register read strobe (clears overrun) |
| rd_data | output | 8 | Head character, or 0x00 |
| stat_rdy | output | 1 | Queue holds at least one character |
| stat_perr | output | 1 | Parity error of the head character |
| stat_ferr | output | 1 | Framing error of the head character |
| stat_brk | output | 1 | Break flag of the head character |
| stat_ovr | output | 1 | Sticky overrun flag |

## Verification
A wrong read or write pointer shows on `rd_data` at the first read after the fault. The wrong byte appears, or a byte comes twice or is skipped. The bench reads every character of every fill back, so the fault is caught within one queue depth of reads. Flags stored in the wrong slot show on the status port as soon as that slot reaches the head, and status is compared after every single read. A wrong count shows within one cycle as a wrong `stat_rdy`, or as a wrong `stat_ovr` at the next push into a full queue.

// File: rtl/rx_char_queue_pkg.sv
// Shared types for the receive character queue.
// Assumes characters of at most 8 bits and a fixed set of three error flags.
package rx_char_queue_pkg;

    localparam int CHAR_W = 8;
    localparam int MIN_W  = 5;

    typedef enum logic [1:0] {
        LEN5 = 2'd0,
        LEN6 = 2'd1,
        LEN7 = 2'd2,
        LEN8 = 2'd3
    } char_len_e;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rx_char_pack.sv
// Builds one queue entry from a received character.
// Clears every data bit at or above the selected width and keeps bit 0 as
// the first bit on the line. Purely combinational.
module rx_char_pack
    import rx_char_queue_pkg::*;
(
    input  logic [CHAR_W-1:0] in_data,
    input  char_len_e         in_len,
    input  logic              in_perr,
    input  logic              in_ferr,
    input  logic              in_brk,
    output rx_entry_t         out_entry
);

    logic [CHAR_W-1:0] keep_mask;

    // One mask bit per data bit: the low MIN_W bits always pass, the rest
    // pass only when the width code reaches them.
    for (genvar b = 0; b < CHAR_W; b++) begin : g_mask
        if (b < MIN_W) begin : g_fixed
            assign keep_mask[b] = 1'b1;
        end else begin : g_var
            assign keep_mask[b] = (int'(in_len) >= (b - MIN_W + 1));
        end
    end

    // Put the masked byte and the flags together into an entry.
    always_comb begin
        out_entry.data = in_data & keep_mask;
        out_entry.perr = in_perr;
        out_entry.ferr = in_ferr;
        out_entry.brk  = in_brk;
    end

endmodule

// File: rtl/rx_queue_store.sv
// Circular storage for queue entries with read and write pointers and an
// occupancy count. A write into a full store is accepted only when a read
// is accepted in the same cycle; otherwise it is reported on push_drop.
// A clear empties the store and zeroes every slot; it overrides all else.
// Works for any DEPTH >= 2.
module rx_queue_store
    import rx_char_queue_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head_entry,
    output logic      empty,
    output logic      full,
    output logic      push_drop
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rx_entry_t         slots [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              pop_ok;
    logic              push_ok;

    // Decide which requests are taken this cycle.
    always_comb begin
        empty     = (count == '0);
        full      = (count == FULL_CNT);
        pop_ok    = pop && !empty;
        push_ok   = push && (!full || pop_ok);
        push_drop = push && !push_ok;
    end

    // Move the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                count <= count + 1'b1;
            end else if (pop_ok && !push_ok) begin
                count <= count - 1'b1;
            end
        end
    end

    // Write the entry into its slot, or wipe all slots on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (push_ok) begin
            slots[wr_ptr] <= push_entry;
        end
    end

    // The oldest entry is always at the read pointer.
    always_comb begin
        head_entry = slots[rd_ptr];
    end

endmodule

// File: rtl/rx_read_port.sv
// Host-side view of the queue head. Gates data reads with the access
// select and blanks outputs when the queue is empty. Holds the sticky
// overrun flag: a discard sets it, and a status read with no discard in
// the same cycle clears it.
module rx_read_port
    import rx_char_queue_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sel_alt,
    input  logic              data_rd,
    input  logic              stat_rd,
    input  rx_entry_t         head_entry,
    input  logic              empty,
    input  logic              push_drop,
    output logic              pop_req,
    output logic [CHAR_W-1:0] rd_data,
    output logic              stat_perr,
    output logic              stat_ferr,
    output logic              stat_brk,
    output logic              stat_ovr
);

    // Present the head byte and its flags, or zeros when nothing is there.
    always_comb begin
        pop_req   = data_rd && !sel_alt;
        rd_data   = (!sel_alt && !empty) ? head_entry.data : '0;
        stat_perr = !empty && head_entry.perr;
        stat_ferr = !empty && head_entry.ferr;
        stat_brk  = !empty && head_entry.brk;
    end

    // Sticky overrun: clear has priority, then a discard, then a status read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stat_ovr <= 1'b0;
        end else if (push_drop) begin
            stat_ovr <= 1'b1;
        end else if (stat_rd) begin
            stat_ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_char_queue.sv
// Receive character queue for a UART. Stores each character with its
// parity, framing and break flags, and presents the oldest one with its own
// flags to the host. Assumes one character strobe per cycle at most and
// single-cycle read strobes from the bus.
module rx_char_queue
    import rx_char_queue_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clr,
    input  logic              char_vld,
    input  logic [CHAR_W-1:0] char_data,
    input  logic [1:0]        char_len,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic              char_brk,
    input  logic              sel_alt,
    input  logic              data_rd,
    input  logic              stat_rd,
    output logic [CHAR_W-1:0] rd_data,
    output logic              stat_rdy,
    output logic              stat_perr,
    output logic              stat_ferr,
    output logic              stat_brk,
    output logic              stat_ovr
);

    rx_entry_t new_entry;
    rx_entry_t head_entry;
    logic      q_empty;
    logic      q_full;
    logic      q_drop;
    logic      q_pop;

    rx_char_pack u_pack (
        .in_data   (char_data),
        .in_len    (char_len_e'(char_len)),
        .in_perr   (char_perr),
        .in_ferr   (char_ferr),
        .in_brk    (char_brk),
        .out_entry (new_entry)
    );

    rx_queue_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .push       (char_vld),
        .push_entry (new_entry),
        .pop        (q_pop),
        .head_entry (head_entry),
        .empty      (q_empty),
        .full       (q_full),
        .push_drop  (q_drop)
    );

    rx_read_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .sel_alt    (sel_alt),
        .data_rd    (data_rd),
        .stat_rd    (stat_rd),
        .head_entry (head_entry),
        .empty      (q_empty),
        .push_drop  (q_drop),
        .pop_req    (q_pop),
        .rd_data    (rd_data),
        .stat_perr  (stat_perr),
        .stat_ferr  (stat_ferr),
        .stat_brk   (stat_brk),
        .stat_ovr   (stat_ovr)
    );

    // Ready means the store holds at least one entry.
    always_comb begin
        stat_rdy = !q_empty;
    end

endmodule

// File: rtl/rx_char_queue_chk.sv
// Property checker for rx_char_queue, attached with bind below.
module rx_char_queue_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_clr,
    input logic       char_vld,
    input logic [1:0] char_len,
    input logic       sel_alt,
    input logic       data_rd,
    input logic       stat_rd,
    input logic [7:0] rd_data,
    input logic       stat_rdy,
    input logic       stat_perr,
    input logic       stat_ferr,
    input logic       stat_brk,
    input logic       stat_ovr,
    input logic       q_full,
    input logic       q_pop
);

    a_r1_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (!stat_rdy && !stat_ovr));

    a_r3_short_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && !stat_rdy && !fifo_clr && char_len == 2'd0)
        |=> (sel_alt || rd_data[7:5] == 3'b000));

    a_r5_status_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !data_rd && stat_rdy && !fifo_clr) |=> stat_rdy);

    a_r6_alt_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        sel_alt |-> (rd_data == 8'h00));

    a_r6_alt_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_alt && data_rd && stat_rdy && !fifo_clr) |=> stat_rdy);

    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && q_full && !q_pop && !fifo_clr) |=> stat_ovr);

    a_r8_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && q_full && q_pop && !fifo_clr && !stat_ovr) |=> !stat_ovr);

    a_r9_ready_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && !fifo_clr) |=> stat_rdy);

    a_r10_empty_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rdy |-> (rd_data == 8'h00 && !stat_perr && !stat_ferr && !stat_brk));

    a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (!stat_rdy && !stat_ovr));

endmodule

bind rx_char_queue rx_char_queue_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_clr  (fifo_clr),
    .char_vld  (char_vld),
    .char_len  (char_len),
    .sel_alt   (sel_alt),
    .data_rd   (data_rd),
    .stat_rd   (stat_rd),
    .rd_data   (rd_data),
    .stat_rdy  (stat_rdy),
    .stat_perr (stat_perr),
    .stat_ferr (stat_ferr),
    .stat_brk  (stat_brk),
    .stat_ovr  (stat_ovr),
    .q_full    (q_full),
    .q_pop     (q_pop)
);

// File: tb/rx_char_queue_tb.sv
module rx_char_queue_tb;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_clr = 1'b0;
    logic       char_vld = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic [1:0] char_len = 2'd0;
    logic       char_perr = 1'b0;
    logic       char_ferr = 1'b0;
    logic       char_brk = 1'b0;
    logic       sel_alt = 1'b0;
    logic       data_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       stat_rdy;
    logic       stat_perr;
    logic       stat_ferr;
    logic       stat_brk;
    logic       stat_ovr;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // Reference queue: {brk, ferr, perr, data}
    logic [10:0] mq [$];
    logic        m_ovr = 1'b0;

    always #10 clk = ~clk;

    rx_char_queue #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr),
        .char_vld(char_vld), .char_data(char_data), .char_len(char_len),
        .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
        .sel_alt(sel_alt), .data_rd(data_rd), .stat_rd(stat_rd),
        .rd_data(rd_data), .stat_rdy(stat_rdy), .stat_perr(stat_perr),
        .stat_ferr(stat_ferr), .stat_brk(stat_brk), .stat_ovr(stat_ovr)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare all outputs with the reference model.
    task automatic compare_all();
        logic [10:0] h;
        h = (mq.size() > 0) ? mq[0] : 11'd0;
        chk("R2 head data", rd_data, (!sel_alt && mq.size() > 0) ? h[7:0] : 8'h00);
        chk("R4 head flags", {5'd0, stat_brk, stat_ferr, stat_perr}, {5'd0, h[10:8]});
        chk("R9 ready", {7'd0, stat_rdy}, {7'd0, mq.size() > 0});
        chk("R7 overrun", {7'd0, stat_ovr}, {7'd0, m_ovr});
    endtask

    // Apply one cycle of inputs, advance the model, then compare.
    task automatic cyc(input logic vld, input logic [7:0] d, input logic [1:0] len,
                       input logic [2:0] flg, input logic sel, input logic drd,
                       input logic srd, input logic clr);
        logic [8:0] msk;
        bit         pop;
        bit         acc;
        char_vld = vld; char_data = d; char_len = len;
        {char_brk, char_ferr, char_perr} = flg;
        sel_alt = sel; data_rd = drd; stat_rd = srd; fifo_clr = clr;
        @(posedge clk);
        msk = (9'd1 << (5 + int'(len))) - 9'd1;
        if (clr) begin
            mq.delete();
            m_ovr = 1'b0;
        end else begin
            pop = drd && !sel && (mq.size() > 0);
            acc = vld && ((mq.size() < DEPTH) || pop);
            if (pop) void'(mq.pop_front());
            if (acc) mq.push_back({flg, d & msk[7:0]});
            if (vld && !acc) m_ovr = 1'b1;
            else if (srd) m_ovr = 1'b0;
        end
        #5;
        compare_all();
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic push(input logic [7:0] d, input logic [1:0] len, input logic [2:0] flg);
        cyc(1'b1, d, len, flg, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd_pair();
        cyc(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rdy", {7'd0, stat_rdy}, 8'h00);
        chk("R1 ovr", {7'd0, stat_ovr}, 8'h00);
        chk("R1 data", rd_data, 8'h00);
        chk("R1 flags", {5'd0, stat_brk, stat_ferr, stat_perr}, 8'h00);

        // R10: read on empty queue
        cyc(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10 empty read", rd_data, 8'h00);
        push(8'h3C, 2'd3, 3'b010);
        chk("R10 next char", rd_data, 8'h3C);
        chk("R4 ferr only", {5'd0, stat_brk, stat_ferr, stat_perr}, 8'h02);

        // R3: 5-bit character keeps bits 4:0 only
        push(8'hFF, 2'd0, 3'b000);
        // R5: status read keeps head
        cyc(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 head kept", rd_data, 8'h3C);
        // R6: alternate bank blanks data and does not pop
        cyc(1'b0, 8'h00, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R6 blank", rd_data, 8'h00);
        cyc(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R6 no pop", rd_data, 8'hFF & 8'h1F);
        chk("R3 len5", rd_data, 8'h1F);

        // R11: clear overrides a char in the same cycle
        cyc(1'b1, 8'h55, 2'd3, 3'b111, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R11 empty", {7'd0, stat_rdy}, 8'h00);

        // Sweep every byte under every width code
        for (int len = 0; len < 4; len++) begin
            for (int v = 0; v < 256; v++) begin
                push(8'(v), 2'(len), 3'(v));
                if (mq.size() == DEPTH) begin
                    // R8: full plus read plus char in one cycle
                    cyc(1'b1, 8'(v ^ 8'h5A), 2'(len), 3'd5, 1'b0, 1'b1, 1'b0, 1'b0);
                    chk("R8 no overrun", {7'd0, stat_ovr}, 8'h00);
                    // R7: full, char dropped
                    push(8'(v ^ 8'hA5), 2'(len), 3'd7);
                    chk("R7 overrun set", {7'd0, stat_ovr}, 8'h01);
                    for (int k = 0; k < DEPTH; k++) begin
                        if ((k % 4) == 1)
                            cyc(1'b0, 8'h00, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0);
                        rd_pair();
                    end
                    chk("R7 drained", {7'd0, stat_rdy}, 8'h00);
                end
            end
        end
        while (mq.size() > 0) rd_pair();

        // R11: clear also drops overrun and partial content
        for (int k = 0; k < DEPTH + 1; k++) push(8'(k), 2'd3, 3'd1);
        cyc(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R11 ovr clear", {7'd0, stat_ovr}, 8'h00);
        push(8'h81, 2'd3, 3'd4);
        chk("R11 fresh", rd_data, 8'h81);
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule